// File: doc/BRIEF.md
# Fixed-Point Load-Family Execution Unit

This unit performs the register-to-register load variants of a fixed-point pipeline on 32-bit signed operands. One operation is presented together with an input strobe. The unit then returns the 32-bit value to be written back. For the variants that update the condition code, it also returns a two-bit code with a write enable. When an overflow occurs and software has enabled fixed-point-overflow interrupts, it raises an interrupt request.

The variants are:

- plain load;
- load-and-test;
- two's complement;
- positive absolute value;
- negative absolute value;
- sign-extending halfword load;
- 24-bit address load.

The halfword and address variants take their value from dedicated inputs, which an earlier stage supplies. All other variants use the 32-bit operand. Every result is registered, so a single issue slot yields one output cycle, marked by an output strobe. Instruction decode, register file, storage access and address generation sit outside the unit.

Top module: `fxload_unit`

## Requirements
- R1: An operation sampled with `inValid` high at a rising clock edge produces its `result`, `ccWe`, `ccOut` and `ovfIrq` on the following cycle, with `outValid` high for exactly that one cycle. Without `inValid`, `outValid`, `ccWe` and `ovfIrq` are low on the next cycle.
- R2: While `rstN` is low, and after its release until the first operation, every output is zero.
- R3: `opSel` = 1 (test) passes `operandB` unchanged. Its code is 0 for zero, 1 for negative and 2 for positive.
- R4: `opSel` = 2 (complement) returns the two's complement of `operandB`, with code 0, 1 or 2 from the sign of the result. The most negative value 0x80000000 is returned unchanged with code 3.
- R5: `opSel` = 4 (positive) returns the absolute value, with code 0 for zero and 2 for nonzero. The most negative value is returned unchanged with code 3.
- R6: `opSel` = 3 (negative) negates positive values and leaves zero and negative values unchanged. Its code is 0 or 1, never 3, and it never requests an interrupt.
- R7: An overflow (code 3) raises `ovfIrq` only when `ovfMask` was 1 with the operation. With the mask 0, code 3 is still produced and `ovfIrq` stays low.
- R8: `opSel` = 5 (halfword) returns `halfIn` with bit 15 copied into result bits 31..16, ignoring `operandB`.
- R9: `opSel` = 6 (address) returns `addrIn` in result bits 23..0 with bits 31..24 forced to zero, ignoring `operandB`.
- R10: `opSel` = 0 (load), and the unused code 7, return `operandB` unchanged.
- R11: `ccWe` is high only for `opSel` 1 to 4. For opSel 0, 5, 6 and 7, `ccWe`, `ccOut` and `ovfIrq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation issue strobe |
| opSel | input | 3 | Variant select (encoding in R3 to R11) |
| operandB | input | 32 | Second operand |
| halfIn | input | 16 | Halfword operand for the sign-extending load |
| addrIn | input | 24 | Computed address for the address load |
| ovfMask | input | 1 | Fixed-point-overflow interrupt mask |
| outValid | output | 1 | Result strobe, one cycle after issue |
| result | output | 32 | Value to write back |
| ccWe | output | 1 | Condition-code update enable |
| ccOut | output | 2 | Condition code |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
The checker relates each output cycle to the inputs of the cycle before. It therefore assumes that `opSel` and `ovfMask` are held with `inValid` for the issue cycle and are known whenever `inValid` is high. The scoreboard drives every input field on the falling edge and keeps it for the whole issue cycle. It issues both back-to-back and separated by idle cycles. In the halfword and address cases it fills `operandB` with patterns that must not reach the result.

// File: rtl/fxload_pkg.sv
package fxload_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_TEST = 3'd1,
    OP_COMP = 3'd2,
    OP_NABS = 3'd3,
    OP_PABS = 3'd4,
    OP_HALF = 3'd5,
    OP_ADDR = 3'd6,
    OP_RSVD = 3'd7
  } opcode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic selHalf;    // take value from halfword input
    logic selAddr;    // take value from address input
    logic negAlways;  // unconditional two's complement
    logic negIfNeg;   // negate only negative values
    logic negIfPos;   // negate only positive values
    logic ccUpd;      // variant writes the condition code
    logic ovfEn;      // variant can overflow
  } ctrlStrobes_t;

  localparam logic [1:0] CC_ZERO = 2'd0;
  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_POS  = 2'd2;
  localparam logic [1:0] CC_OVF  = 2'd3;
endpackage

// File: rtl/fxload_ctrl.sv
module fxload_ctrl
  import fxload_pkg::*;
(
  input  logic [2:0]   opSel,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    unique case (opSel)
      OP_TEST: strobes.ccUpd = 1'b1;
      OP_COMP: begin
        strobes.negAlways = 1'b1;
        strobes.ccUpd     = 1'b1;
        strobes.ovfEn     = 1'b1;
      end
      OP_NABS: begin
        strobes.negIfPos = 1'b1;
        strobes.ccUpd    = 1'b1;
      end
      OP_PABS: begin
        strobes.negIfNeg = 1'b1;
        strobes.ccUpd    = 1'b1;
        strobes.ovfEn    = 1'b1;
      end
      OP_HALF: strobes.selHalf = 1'b1;
      OP_ADDR: strobes.selAddr = 1'b1;
      default: strobes = '0;  // load and reserved code
    endcase
  end
endmodule

// File: rtl/fxload_dp.sv
module fxload_dp
  import fxload_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] operandB,
  input  logic [HALF_W-1:0] halfIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ovfMask,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              ccWe,
  output logic [1:0]        ccOut,
  output logic              ovfIrq
);
  localparam int EXT_W = DATA_W - HALF_W;
  localparam int TOP_W = DATA_W - ADDR_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] srcVal, nextRes;
  logic              srcNeg, srcZero, srcMin, doNegate, ovfNow;
  logic [1:0]        nextCc;

  always_comb begin
    if (strobes.selHalf)
      srcVal = {{EXT_W{halfIn[HALF_W-1]}}, halfIn};
    else if (strobes.selAddr)
      srcVal = {{TOP_W{1'b0}}, addrIn};
    else
      srcVal = operandB;
  end

  assign srcNeg   = srcVal[DATA_W-1];
  assign srcZero  = (srcVal == '0);
  assign srcMin   = (srcVal == MOST_NEG);
  assign doNegate = strobes.negAlways
                  | (strobes.negIfNeg & srcNeg)
                  | (strobes.negIfPos & ~srcNeg & ~srcZero);
  assign nextRes  = doNegate ? (~srcVal + 1'b1) : srcVal;
  assign ovfNow   = strobes.ovfEn & doNegate & srcMin;

  always_comb begin
    if (!strobes.ccUpd)          nextCc = CC_ZERO;
    else if (ovfNow)             nextCc = CC_OVF;
    else if (nextRes == '0)      nextCc = CC_ZERO;
    else if (nextRes[DATA_W-1])  nextCc = CC_NEG;
    else                         nextCc = CC_POS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      ccWe     <= 1'b0;
      ccOut    <= CC_ZERO;
      ovfIrq   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result <= nextRes;
        ccOut  <= nextCc;
      end
      ccWe   <= inValid & strobes.ccUpd;
      ovfIrq <= inValid & ovfNow & ovfMask;
    end
  end
endmodule

// File: rtl/fxload_unit.sv
module fxload_unit
  import fxload_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  opSel,
  input  logic [31:0] operandB,
  input  logic [15:0] halfIn,
  input  logic [23:0] addrIn,
  input  logic        ovfMask,
  output logic        outValid,
  output logic [31:0] result,
  output logic        ccWe,
  output logic [1:0]  ccOut,
  output logic        ovfIrq
);
  ctrlStrobes_t strobes;

  fxload_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  fxload_dp #(.DATA_W(32), .HALF_W(16), .ADDR_W(24)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .operandB (operandB),
    .halfIn   (halfIn),
    .addrIn   (addrIn),
    .ovfMask  (ovfMask),
    .outValid (outValid),
    .result   (result),
    .ccWe     (ccWe),
    .ccOut    (ccOut),
    .ovfIrq   (ovfIrq)
  );
endmodule

// File: rtl/fxload_chk.sv
module fxload_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  opSel,
  input logic        ovfMask,
  input logic        outValid,
  input logic [31:0] result,
  input logic        ccWe,
  input logic [1:0]  ccOut,
  input logic        ovfIrq
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !ccWe && !ovfIrq));
  p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> ($past(ovfMask) && ccOut == 2'd3 && outValid));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 3'd3) |-> (ccOut != 2'd3 && !ovfIrq));
  p_addr_top_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 3'd6) |-> (result[31:24] == 8'd0));
  p_cc_we_ops_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (ccWe == ($past(opSel) >= 3'd1 && $past(opSel) <= 3'd4)));
  p_pabs_codes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 3'd4) |-> (ccOut != 2'd1));
endmodule

bind fxload_unit fxload_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .ovfMask  (ovfMask),
  .outValid (outValid),
  .result   (result),
  .ccWe     (ccWe),
  .ccOut    (ccOut),
  .ovfIrq   (ovfIrq)
);

// File: tb/sim_fxload_unit.sv
`timescale 1ns/1ps
module sim_fxload_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] operandB = '0;
  logic [15:0] halfIn = '0;
  logic [23:0] addrIn = '0;
  logic        ovfMask = 1'b0;
  logic        outValid, ccWe, ovfIrq;
  logic [31:0] result;
  logic [1:0]  ccOut;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [1:0]  cc;
    logic        irq;
    int          cyc;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  fxload_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .operandB(operandB), .halfIn(halfIn), .addrIn(addrIn), .ovfMask(ovfMask),
    .outValid(outValid), .result(result), .ccWe(ccWe), .ccOut(ccOut),
    .ovfIrq(ovfIrq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [1:0] signCode(input logic [31:0] v);
    if (v == 32'd0) return 2'd0;
    if (v[31])      return 2'd1;
    return 2'd2;
  endfunction

  // Reference model written from the requirements
  function automatic expItem_t model(input logic [2:0] op, input logic [31:0] b,
                                     input logic [15:0] h, input logic [23:0] a,
                                     input logic m);
    expItem_t e;
    e.res = b; e.we = 1'b0; e.cc = 2'd0; e.irq = 1'b0; e.cyc = 0; e.tag = "";
    case (op)
      3'd1: begin e.we = 1'b1; e.cc = signCode(b); end
      3'd2: begin
        e.we = 1'b1;
        if (b == 32'h8000_0000) begin e.cc = 2'd3; e.irq = m; end
        else begin e.res = -b; e.cc = signCode(e.res); end
      end
      3'd3: begin
        e.we = 1'b1;
        e.res = ($signed(b) > 0) ? -b : b;
        e.cc = signCode(e.res);
      end
      3'd4: begin
        e.we = 1'b1;
        if (b == 32'h8000_0000) begin e.cc = 2'd3; e.irq = m; end
        else begin e.res = b[31] ? -b : b; e.cc = signCode(e.res); end
      end
      3'd5: e.res = {{16{h[15]}}, h};
      3'd6: e.res = {8'h00, a};
      default: e.res = b;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [31:0] b,
                       input logic [15:0] h, input logic [23:0] a,
                       input logic m, input string tag);
    expItem_t e;
    @(negedge clk);
    opSel = op; operandB = b; halfIn = h; addrIn = a; ovfMask = m;
    inValid = 1'b1;
    e = model(op, b, h, a, m);
    e.cyc = cycleCnt + 1;
    e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      operandB = 32'hDEAD_BEEF;
      opSel = 3'd2;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done && outValid) begin
      expItem_t e;
      checks++;
      if (sbQ.size() == 0) begin
        errors++;
        $display("FAIL R1: outValid with nothing issued, act=1 exp=0");
      end else begin
        e = sbQ.pop_front();
        if (result !== e.res || ccWe !== e.we || ccOut !== e.cc ||
            ovfIrq !== e.irq || cycleCnt != e.cyc) begin
          errors++;
          $display("FAIL %s: act res=%h we=%b cc=%0d irq=%b cyc=%0d exp res=%h we=%b cc=%0d irq=%b cyc=%0d",
                   e.tag, result, ccWe, ccOut, ovfIrq, cycleCnt,
                   e.res, e.we, e.cc, e.irq, e.cyc);
        end
      end
    end else if (rstN && !done && (ccWe || ovfIrq)) begin
      checks++;
      errors++;
      $display("FAIL R1: strobes without outValid, act we=%b irq=%b exp 0 0", ccWe, ovfIrq);
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R2 reset state
    if ({outValid, result, ccWe, ccOut, ovfIrq} !== '0) begin
      errors++;
      $display("FAIL R2: act=%h exp=0", {outValid, result, ccWe, ccOut, ovfIrq});
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;  // R2 after release
    if ({outValid, result, ccWe, ccOut, ovfIrq} !== '0) begin
      errors++;
      $display("FAIL R2: act=%h exp=0", {outValid, result, ccWe, ccOut, ovfIrq});
    end

    issue(3'd0, 32'h1234_5678, 16'h0, 24'h0, 1'b1, "R10");
    issue(3'd7, 32'h8765_4321, 16'h0, 24'h0, 1'b1, "R10");
    idle(2);
    issue(3'd1, 32'h0, 16'h0, 24'h0, 1'b0, "R3");
    issue(3'd1, 32'h8000_0001, 16'h0, 24'h0, 1'b0, "R3");
    issue(3'd1, 32'h0000_0005, 16'h0, 24'h0, 1'b1, "R3");
    idle(1);
    issue(3'd2, 32'h5, 16'h0, 24'h0, 1'b0, "R4");
    issue(3'd2, 32'h0, 16'h0, 24'h0, 1'b0, "R4");
    issue(3'd2, 32'hFFFF_FFF9, 16'h0, 24'h0, 1'b0, "R4");
    issue(3'd2, 32'h8000_0000, 16'h0, 24'h0, 1'b1, "R4");
    issue(3'd2, 32'h8000_0000, 16'h0, 24'h0, 1'b0, "R7");
    idle(1);
    issue(3'd4, 32'hFFFF_FFFD, 16'h0, 24'h0, 1'b0, "R5");
    issue(3'd4, 32'h9, 16'h0, 24'h0, 1'b0, "R5");
    issue(3'd4, 32'h0, 16'h0, 24'h0, 1'b0, "R5");
    issue(3'd4, 32'h8000_0000, 16'h0, 24'h0, 1'b1, "R7");
    idle(3);
    issue(3'd3, 32'h4, 16'h0, 24'h0, 1'b1, "R6");
    issue(3'd3, 32'hFFFF_FFFC, 16'h0, 24'h0, 1'b1, "R6");
    issue(3'd3, 32'h0, 16'h0, 24'h0, 1'b1, "R6");
    issue(3'd3, 32'h8000_0000, 16'h0, 24'h0, 1'b1, "R6");
    issue(3'd5, 32'h0123_4567, 16'h8001, 24'h0, 1'b1, "R8");
    issue(3'd5, 32'hFFFF_FFFF, 16'h7FFF, 24'h0, 1'b1, "R8");
    issue(3'd6, 32'hFFFF_FFFF, 16'hFFFF, 24'hABCDEF, 1'b1, "R9");
    issue(3'd6, 32'h8000_0000, 16'h0, 24'h000001, 1'b1, "R11");
    idle(4);

    checks++;  // R1: every issued item came out
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL R1: act pending=%0d exp=0", sbQ.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule